// File: doc/BRIEF.md
# Device Command Mailbox Engine

This block is the device end of a command window that a host drives through a small memory-mapped register port. The host fills a command area, writes 0 to the done register, and then writes 1 to the doorbell register. The engine captures the opcode from the low byte of the first command word and runs a stub handler. The handler takes a programmable number of cycles. The engine then stores a completion status byte and sets the done bit, which the host polls.

The host may give up on a command. It does this by writing 0 to the doorbell and zeroing the command area. The engine then drops the command without reporting completion.

A read-only firmware status byte carries a running flag and a generation field. The generation field advances each time a firmware-control command completes, so a host that kept an earlier copy of it can detect a restart. The latency register lets a test force either prompt completion or a host timeout.

The register port is plain, not a stream: writes take effect at the clock edge where the write strobe is high. Read data is registered, so it appears one cycle after the read strobe. There is no back-pressure; every access completes in one cycle.

Top module: `dev_cmd_mailbox`

## Requirements
- R1: After reset the done register reads 0, the status register reads 0, the latency register reads 4, every command word reads 0 and the firmware status reads 0x01.
- R2: A write at word address 0 with bit 0 set, while the engine is idle, captures bits 7:0 of command word 0 as the opcode and clears done. With latency L held in the latency register, done bit 0 becomes visible after L+1 clock edges.
- R3: Done bit 0 (word address 1) is set only when a command completes. A write to address 1 with bit 0 clear clears it. A write with bit 0 set has no effect.
- R4: The status register (address 2) holds the completion status:
  - 0x00 for the known opcodes NOP=0x00, IDENTIFY=0x01, RESET=0x02, INIT=0x03, FW_DOWNLOAD=0x04 and FW_CONTROL=0x05;
  - 0x21 for any other opcode, which still completes.
- R5: The latency register (address 4, 16 bits) can be read and written at run time. A command uses the value held at its doorbell edge.
- R6: A doorbell write while a command is busy is ignored. The running command completes once, and no second command follows.
- R7: A command is dropped when three conditions hold on a clock edge: the engine is busy, the stored doorbell bit is 0, and all command words are 0. The engine then returns to idle without setting done.
- R8: The firmware status (address 3) has the running flag in bit 0 and the generation in bits 6:4; bit 7 is always 0, so it never reads 0xFF.
  - The running flag reads 0 while a FW_CONTROL command is busy.
  - The generation rises by 1, modulo 8, when a FW_CONTROL command completes.
- R9: Command words at addresses 8 to 11 can be read and written. Writing them while a command is busy does not change that command's result.
- R10: Read data updates on the clock edge where the read strobe is high and holds otherwise. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 6 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 32 | Registered read data |

## Verification
The hardest state to reach from the ports is the abandoned command. The command must still be in flight when the host's cleanup writes land: first a zero to the doorbell, then zeros over the command area. The stimulus achieves this by programming a long latency before ringing. It then performs the cleanup and idles well past the original deadline, to show that done never rises. A doorbell written again mid-command, with the opcode word also rewritten, is handled the same way. The bench checks that exactly one completion follows, carrying the original opcode's status.

// File: rtl/mb_pkg.sv
package mb_pkg;
  localparam int ADR_RING = 0;
  localparam int ADR_DONE = 1;
  localparam int ADR_STAT = 2;
  localparam int ADR_FW   = 3;
  localparam int ADR_LAT  = 4;
  localparam int ADR_CMD  = 8;

  typedef enum logic [7:0] {
    OP_NOP      = 8'h00,
    OP_IDENTIFY = 8'h01,
    OP_RESET    = 8'h02,
    OP_INIT     = 8'h03,
    OP_FW_DL    = 8'h04,
    OP_FW_CTRL  = 8'h05
  } op_e;

  localparam logic [7:0] ST_OK    = 8'h00;
  localparam logic [7:0] ST_BADOP = 8'h21;

  function automatic logic [7:0] status_for(input logic [7:0] op);
    logic [7:0] s;
    s = (op <= 8'(OP_FW_CTRL)) ? ST_OK : ST_BADOP;
    return s;
  endfunction
endpackage

// File: rtl/mb_regs.sv
module mb_regs #(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 6,
  parameter int CMD_WORDS = 4,
  parameter int LAT_W     = 16,
  parameter int DEF_LAT   = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [DATA_W-1:0]           wdata,
  output logic [CMD_WORDS*DATA_W-1:0] cmd_flat,
  output logic [LAT_W-1:0]            lat_q,
  output logic                        ring_q,
  output logic                        cmd_zero,
  output logic                        start_req,
  output logic                        done_clr
);
  import mb_pkg::*;

  logic hit_ring, hit_done, hit_lat;
  assign hit_ring  = wr_en && (addr == ADDR_W'(ADR_RING));
  assign hit_done  = wr_en && (addr == ADDR_W'(ADR_DONE));
  assign hit_lat   = wr_en && (addr == ADDR_W'(ADR_LAT));
  assign start_req = hit_ring && wdata[0];
  assign done_clr  = hit_done && !wdata[0];
  assign cmd_zero  = ~|cmd_flat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ring_q <= 1'b0;
      lat_q  <= LAT_W'(DEF_LAT);
    end else begin
      if (hit_ring) ring_q <= wdata[0];
      if (hit_lat)  lat_q  <= wdata[LAT_W-1:0];
    end
  end

  for (genvar g = 0; g < CMD_WORDS; g++) begin : g_word
    logic hit_w;
    assign hit_w = wr_en && (addr == ADDR_W'(ADR_CMD + g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cmd_flat[g*DATA_W +: DATA_W] <= '0;
      else if (hit_w) cmd_flat[g*DATA_W +: DATA_W] <= wdata;
    end
  end
endmodule

// File: rtl/mb_seq.sv
module mb_seq #(
  parameter int LAT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic             done_clr,
  input  logic [7:0]       opcode_in,
  input  logic [LAT_W-1:0] lat_in,
  input  logic             ring_q,
  input  logic             cmd_zero,
  output logic             busy,
  output logic [7:0]       op_q,
  output logic             done_q,
  output logic [7:0]       status_q,
  output logic             fw_restart
);
  import mb_pkg::*;

  logic [LAT_W-1:0] cnt_q;
  logic             abandon, complete;

  assign abandon    = busy && !ring_q && cmd_zero;
  assign complete   = busy && !abandon && (cnt_q == '0);
  assign fw_restart = complete && (op_q == 8'(OP_FW_CTRL));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cnt_q    <= '0;
      op_q     <= '0;
      done_q   <= 1'b0;
      status_q <= ST_OK;
    end else begin
      if (busy) begin
        if (abandon) begin
          busy <= 1'b0;
        end else if (complete) begin
          busy     <= 1'b0;
          done_q   <= 1'b1;
          status_q <= status_for(op_q);
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end else if (start_req) begin
        busy   <= 1'b1;
        op_q   <= opcode_in;
        cnt_q  <= lat_in;
        done_q <= 1'b0;
      end
      if (done_clr && !complete) done_q <= 1'b0;
    end
  end
endmodule

// File: rtl/mb_fwstat.sv
module mb_fwstat #(
  parameter int GEN_W = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic       halted,
  output logic [7:0] fw_byte
);
  localparam int GEN_LSB = 4;
  logic [GEN_W-1:0] gen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gen_q <= '0;
    else if (restart) gen_q <= gen_q + 1'b1;
  end

  always_comb begin
    fw_byte = '0;
    fw_byte[0] = !halted;
    fw_byte[GEN_LSB +: GEN_W] = gen_q;
  end
endmodule

// File: rtl/dev_cmd_mailbox.sv
module dev_cmd_mailbox #(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 6,
  parameter int CMD_WORDS = 4,
  parameter int LAT_W     = 16,
  parameter int DEF_LAT   = 4,
  parameter int GEN_W     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_wr,
  input  logic              reg_rd,
  output logic [DATA_W-1:0] reg_rdata
);
  import mb_pkg::*;

  logic [CMD_WORDS*DATA_W-1:0] cmd_flat;
  logic [LAT_W-1:0]            lat_q;
  logic                        ring_q, cmd_zero, start_req, done_clr;
  logic                        seq_busy, seq_done, fw_restart;
  logic [7:0]                  seq_op, seq_status, fw_byte;
  logic [DATA_W-1:0]           rd_mux;

  mb_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CMD_WORDS(CMD_WORDS),
            .LAT_W(LAT_W), .DEF_LAT(DEF_LAT)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .cmd_flat(cmd_flat), .lat_q(lat_q),
    .ring_q(ring_q), .cmd_zero(cmd_zero), .start_req(start_req),
    .done_clr(done_clr));

  mb_seq #(.LAT_W(LAT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .done_clr(done_clr),
    .opcode_in(cmd_flat[7:0]), .lat_in(lat_q), .ring_q(ring_q),
    .cmd_zero(cmd_zero), .busy(seq_busy), .op_q(seq_op),
    .done_q(seq_done), .status_q(seq_status), .fw_restart(fw_restart));

  mb_fwstat #(.GEN_W(GEN_W)) u_fw (
    .clk(clk), .rst_n(rst_n), .restart(fw_restart),
    .halted(seq_busy && (seq_op == 8'(OP_FW_CTRL))), .fw_byte(fw_byte));

  always_comb begin
    rd_mux = '0;
    if (reg_addr == ADDR_W'(ADR_RING))      rd_mux = DATA_W'(ring_q);
    else if (reg_addr == ADDR_W'(ADR_DONE)) rd_mux = DATA_W'(seq_done);
    else if (reg_addr == ADDR_W'(ADR_STAT)) rd_mux = DATA_W'(seq_status);
    else if (reg_addr == ADDR_W'(ADR_FW))   rd_mux = DATA_W'(fw_byte);
    else if (reg_addr == ADDR_W'(ADR_LAT))  rd_mux = DATA_W'(lat_q);
    for (int i = 0; i < CMD_WORDS; i++) begin
      if (reg_addr == ADDR_W'(ADR_CMD + i)) rd_mux = cmd_flat[i*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/mb_chk.sv
module mb_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic [7:0] op,
  input logic       ring,
  input logic       cmd_zero,
  input logic       start,
  input logic [7:0] fw
);
  assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  assert_done_after_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy));
  assert_busy_ignore_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(op));
  assert_abandon_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ring && cmd_zero) |=> (!busy && !done));
  assert_fw_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fw != 8'hFF);
  assert_op_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(op));
endmodule

bind dev_cmd_mailbox mb_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(seq_busy), .done(seq_done), .op(seq_op),
  .ring(ring_q), .cmd_zero(cmd_zero), .start(start_req), .fw(fw_byte));

// File: tb/dev_cmd_mailbox_tb.sv
module dev_cmd_mailbox_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [31:0] reg_rdata;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  dev_cmd_mailbox u_dut (.clk(clk), .rst_n(rst_n), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata));

  // Behavioural reference model
  bit          m_busy, m_done, m_ring;
  int          m_cnt, m_lat, m_gen;
  logic [7:0]  m_op, m_status;
  logic [31:0] m_cmd [4];
  logic [31:0] m_rdata;

  function automatic logic [31:0] m_read(input logic [5:0] a);
    logic [31:0] v = 0;
    case (a)
      6'd0: v = {31'd0, m_ring};
      6'd1: v = {31'd0, m_done};
      6'd2: v = {24'd0, m_status};
      6'd3: v = (m_gen << 4) | ((m_busy && m_op == 8'h05) ? 0 : 1);
      6'd4: v = m_lat;
      6'd8, 6'd9, 6'd10, 6'd11: v = m_cmd[a - 8];
      default: v = 0;
    endcase
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_ring = 0; m_cnt = 0; m_lat = 4; m_gen = 0;
      m_op = 0; m_status = 0; m_rdata = 0;
      foreach (m_cmd[i]) m_cmd[i] = 0;
    end else begin
      bit fin;
      bit all_zero;
      fin = 0;
      all_zero = (m_cmd[0] | m_cmd[1] | m_cmd[2] | m_cmd[3]) == 0;
      if (reg_rd) m_rdata = m_read(reg_addr);
      if (m_busy) begin
        if (!m_ring && all_zero) m_busy = 0;
        else if (m_cnt == 0) begin
          m_busy = 0; m_done = 1; fin = 1;
          m_status = (m_op <= 8'h05) ? 8'h00 : 8'h21;
          if (m_op == 8'h05) m_gen = (m_gen + 1) % 8;
        end else m_cnt--;
      end else if (reg_wr && reg_addr == 0 && reg_wdata[0]) begin
        m_busy = 1; m_op = m_cmd[0][7:0]; m_cnt = m_lat; m_done = 0;
      end
      if (reg_wr) begin
        if (reg_addr == 0) m_ring = reg_wdata[0];
        if (reg_addr == 1 && !reg_wdata[0] && !fin) m_done = 0;
        if (reg_addr == 4) m_lat = reg_wdata[15:0];
        if (reg_addr >= 8 && reg_addr <= 11) m_cmd[reg_addr - 8] = reg_wdata;
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // R10: read data compared with the model on every clock
  always @(negedge clk) if (rst_n) check("R10", reg_rdata, m_rdata);

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] v);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0; v = reg_rdata;
  endtask

  task automatic rd_check(input string tag, input logic [5:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(tag, v, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1;
    // R1 reset values
    rd_check("R1 done", 1, 0);
    rd_check("R1 status", 2, 0);
    rd_check("R1 latency R5", 4, 4);
    rd_check("R1 fwstat R8", 3, 32'h01);
    rd_check("R1 cmd R9", 8, 0);
    rd_check("R10 unmapped", 5, 0);
    // R2 / R4 identify
    wr(8, 32'h0000_AA01);
    rd_check("R9 cmd readback", 8, 32'h0000_AA01);
    wr(1, 0);
    wr(0, 1);
    idle(8);
    rd_check("R2 done", 1, 1);
    rd_check("R4 ok status", 2, 8'h00);
    // R3 done clear semantics
    wr(1, 1);
    rd_check("R3 write1 no effect", 1, 1);
    wr(1, 0);
    rd_check("R3 cleared", 1, 0);
    // R4 unknown opcode
    wr(8, 32'h7A);
    wr(0, 1);
    idle(8);
    rd_check("R4 badop done", 1, 1);
    rd_check("R4 badop status", 2, 8'h21);
    // R5 / R8 firmware control
    wr(4, 20);
    rd_check("R5 latency", 4, 20);
    wr(8, 32'h05);
    wr(0, 1);
    rd_check("R8 halted", 3, 32'h00);
    idle(25);
    rd_check("R8 generation", 3, 32'h11);
    rd_check("R4 fwctrl status", 2, 8'h00);
    // R6 / R9 doorbell while busy, command rewritten
    wr(1, 0);
    wr(4, 10);
    wr(8, 32'h02);
    wr(0, 1);
    wr(8, 32'h7A);
    wr(0, 1);
    idle(15);
    rd_check("R6 done once", 1, 1);
    rd_check("R9 original status", 2, 8'h00);
    wr(1, 0);
    idle(30);
    rd_check("R6 no second cmd", 1, 0);
    // R7 abandon
    wr(4, 50);
    wr(8, 32'h03);
    wr(0, 1);
    wr(0, 0);
    wr(8, 0);
    idle(70);
    rd_check("R7 abandoned", 1, 0);
    rd_check("R8 gen kept", 3, 32'h11);
    // R2 prompt completion after abandon
    wr(4, 0);
    wr(8, 32'h7A);
    wr(0, 1);
    idle(2);
    rd_check("R2 prompt done", 1, 1);
    rd_check("R4 prompt status", 2, 8'h21);
    idle(3);
    finish_run();
  end
endmodule